// File: doc/BRIEF.md
# Rotate, Shift, Swap and Bit Unit

This block is the purely combinational datapath behind the prefixed bit-manipulation instructions of a small 8-bit processor core. One operand comes in together with the current flag set, a group select, an operation select and a bit index. The block returns the new operand value, a write-enable for the destination, and the updated flags. It performs circular rotates, rotates through carry, arithmetic and logical shifts and a nibble swap. It also tests, forces and clears single bits.

Instruction decode and operand fetch belong to the surrounding core. The decoder drives the group, the operation and the bit index straight from the opcode fields. It raises `acc_form_i` for the short accumulator-only rotate opcodes, which differ only in how the zero flag is produced. The data width is a parameter. It must be even, at least 2 and a power of two, so that the swap halves and the bit index line up.

Top module: `bitops_unit`

## Requirements
- R1: With group 0 (rotate/shift), operation 0 rotates left with old bit 7 entering bit 0, and operation 1 rotates right with old bit 0 entering bit 7. In both cases C receives the bit that left the operand.
- R2: With group 0, operation 2 shifts left with the incoming C in bit 0, and operation 3 shifts right with the incoming C in bit 7. C receives the old bit 7 or the old bit 0 respectively.
- R3: With group 0, operation 4 shifts left and fills bit 0 with 0. Operation 5 shifts right and keeps bit 7. Operation 7 shifts right and fills bit 7 with 0. In each case C receives the bit shifted out.
- R4: Every group-0 operation drives write-enable high and clears N and H. Z is set exactly when the 8-bit result is zero, unless R8 applies. Flags are packed as {Z,N,H,C} in bits 3..0.
- R5: With group 0, operation 6 exchanges the upper and lower nibbles, clears N, H and C, and sets Z from the result.
- R6: With group 1 (bit test), Z is set exactly when operand bit n is 0, H is set, N is cleared and C is kept. Write-enable is low and the result equals the operand.
- R7: Group 2 clears operand bit n and group 3 sets operand bit n, with all other bits unchanged. Write-enable is high and all four flags pass through unchanged.
- R8: When `acc_form_i` is high with group 0 and operations 0 to 3, Z is forced to 0 and every other output is as in R1/R2. For operations 4 to 7 and for groups 1 to 3, `acc_form_i` has no effect.
- R9: The bit index has no effect on any output in group 0. The operation select has no effect on any output in groups 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 (W) | Operand value |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| grp_i | input | 2 | 0 rotate/shift, 1 bit test, 2 bit clear, 3 bit set |
| op_sel_i | input | 3 | Rotate/shift operation within group 0 |
| bit_idx_i | input | 3 (log2 W) | Bit position for groups 1 to 3 |
| acc_form_i | input | 1 | Accumulator-only rotate form: Z forced low |
| result_o | output | 8 (W) | New operand value |
| wr_en_o | output | 1 | Destination should be written |
| flags_o | output | 4 | New flags {Z,N,H,C} |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle as its stimulus, with no register in any path. The bench changes the inputs on the falling edge of its clock and samples a few nanoseconds later, well before the next rising edge, so each sample sees settled logic for one stimulus only. For the "no effect" requirements, the bench applies a stimulus pair that differs only in the ignored input and compares both sets of outputs against the same expected values.

// File: rtl/bitops_pkg.sv
package bitops_pkg;

   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } flags_t;

   typedef enum logic [1:0] {
      GRP_SHIFT = 2'd0,
      GRP_TEST  = 2'd1,
      GRP_CLEAR = 2'd2,
      GRP_FORCE = 2'd3
   } grp_e;

   typedef enum logic [2:0] {
      OP_ROL_CIRC  = 3'd0,
      OP_ROR_CIRC  = 3'd1,
      OP_ROL_CARRY = 3'd2,
      OP_ROR_CARRY = 3'd3,
      OP_SHL_ARITH = 3'd4,
      OP_SHR_ARITH = 3'd5,
      OP_NIB_SWAP  = 3'd6,
      OP_SHR_LOGIC = 3'd7
   } shop_e;

endpackage

// File: rtl/bitops_shifter.sv
module bitops_shifter
   import bitops_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] opnd_i,
   input  logic         cin_i,
   input  logic [2:0]   op_i,
   output logic [W-1:0] res_o,
   output logic         cout_o
);
   localparam int HALF = W / 2;

   logic [W-1:0] swapped;

   generate
      if (W < 2 || (W % 2) != 0) begin : g_bad_width
         $error("bitops_shifter: W must be even and at least 2");
      end
      assign swapped = {opnd_i[HALF-1:0], opnd_i[W-1:HALF]};
   endgenerate

   always_comb begin
      res_o  = opnd_i;
      cout_o = 1'b0;
      unique case (shop_e'(op_i))
         OP_ROL_CIRC: begin
            res_o  = {opnd_i[W-2:0], opnd_i[W-1]};
            cout_o = opnd_i[W-1];
         end
         OP_ROR_CIRC: begin
            res_o  = {opnd_i[0], opnd_i[W-1:1]};
            cout_o = opnd_i[0];
         end
         OP_ROL_CARRY: begin
            res_o  = {opnd_i[W-2:0], cin_i};
            cout_o = opnd_i[W-1];
         end
         OP_ROR_CARRY: begin
            res_o  = {cin_i, opnd_i[W-1:1]};
            cout_o = opnd_i[0];
         end
         OP_SHL_ARITH: begin
            res_o  = {opnd_i[W-2:0], 1'b0};
            cout_o = opnd_i[W-1];
         end
         OP_SHR_ARITH: begin
            res_o  = {opnd_i[W-1], opnd_i[W-1:1]};
            cout_o = opnd_i[0];
         end
         OP_NIB_SWAP: begin
            res_o  = swapped;
            cout_o = 1'b0;
         end
         OP_SHR_LOGIC: begin
            res_o  = {1'b0, opnd_i[W-1:1]};
            cout_o = opnd_i[0];
         end
         default: begin
            res_o  = opnd_i;
            cout_o = 1'b0;
         end
      endcase
   end

   // R1 R2 R3: carry out always equals one of the two end bits of the operand
   always_comb begin
      if (shop_e'(op_i) != OP_NIB_SWAP) begin
         p_cout_edge_r3: assert (cout_o == opnd_i[W-1] || cout_o == opnd_i[0])
            else $error("p_cout_edge_r3");
      end
   end

endmodule

// File: rtl/bitops_field.sv
module bitops_field
   import bitops_pkg::*;
#(
   parameter int W    = 8,
   parameter int IDXW = $clog2(W)
) (
   input  logic [W-1:0]    opnd_i,
   input  logic [IDXW-1:0] idx_i,
   input  logic            force_i,
   output logic [W-1:0]    res_o,
   output logic            tested_o
);
   logic [W-1:0] sel_mask;

   generate
      if ((1 << IDXW) != W) begin : g_bad_idx
         $error("bitops_field: W must be a power of two matching IDXW");
      end
      for (genvar i = 0; i < W; i++) begin : g_mask
         assign sel_mask[i] = (idx_i == IDXW'(i));
      end
   endgenerate

   assign tested_o = |(opnd_i & sel_mask);
   assign res_o    = force_i ? (opnd_i | sel_mask) : (opnd_i & ~sel_mask);

   // R7: exactly one bit position is ever selected
   always_comb begin
      p_one_bit_mask_r7: assert ($countones(sel_mask) == 1)
         else $error("p_one_bit_mask_r7");
   end

endmodule

// File: rtl/bitops_flags.sv
module bitops_flags
   import bitops_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [1:0]   grp_i,
   input  logic [2:0]   op_i,
   input  logic         acc_form_i,
   input  logic [W-1:0] sh_res_i,
   input  logic         sh_cout_i,
   input  logic         tested_i,
   input  flags_t       flags_i,
   output flags_t       flags_o,
   output logic         wr_en_o
);
   logic acc_z_kill;

   assign acc_z_kill = acc_form_i && (op_i[2] == 1'b0);

   always_comb begin
      flags_o = flags_i;
      wr_en_o = 1'b1;
      unique case (grp_e'(grp_i))
         GRP_SHIFT: begin
            flags_o.z = (sh_res_i == '0) && !acc_z_kill;
            flags_o.n = 1'b0;
            flags_o.h = 1'b0;
            flags_o.c = sh_cout_i;
         end
         GRP_TEST: begin
            flags_o.z = !tested_i;
            flags_o.n = 1'b0;
            flags_o.h = 1'b1;
            flags_o.c = flags_i.c;
            wr_en_o   = 1'b0;
         end
         default: begin
            flags_o = flags_i;
            wr_en_o = 1'b1;
         end
      endcase
   end

   // R4: rotate/shift group leaves N and H clear
   always_comb begin
      if (grp_e'(grp_i) == GRP_SHIFT) begin
         p_shift_nh_clear_r4: assert (!flags_o.n && !flags_o.h)
            else $error("p_shift_nh_clear_r4");
      end
   end

   // R5: nibble swap never reports a carry
   always_comb begin
      if (grp_e'(grp_i) == GRP_SHIFT && shop_e'(op_i) == OP_NIB_SWAP) begin
         p_swap_no_carry_r5: assert (!flags_o.c)
            else $error("p_swap_no_carry_r5");
      end
   end

   // R6: bit test keeps carry and never writes
   always_comb begin
      if (grp_e'(grp_i) == GRP_TEST) begin
         p_test_keeps_c_r6: assert (!wr_en_o && flags_o.h && flags_o.c == flags_i.c)
            else $error("p_test_keeps_c_r6");
      end
   end

   // R7: set/clear leave all flags alone
   always_comb begin
      if (grp_i[1]) begin
         p_field_flags_hold_r7: assert (flags_o == flags_i && wr_en_o)
            else $error("p_field_flags_hold_r7");
      end
   end

   // R8: accumulator-only rotates never report zero
   always_comb begin
      if (grp_e'(grp_i) == GRP_SHIFT && acc_form_i && !op_i[2]) begin
         p_acc_z_low_r8: assert (!flags_o.z)
            else $error("p_acc_z_low_r8");
      end
   end

endmodule

// File: rtl/bitops_unit.sv
module bitops_unit
   import bitops_pkg::*;
#(
   parameter int W    = 8,
   parameter int IDXW = $clog2(W)
) (
   input  logic [W-1:0]    opnd_i,
   input  logic [3:0]      flags_i,
   input  logic [1:0]      grp_i,
   input  logic [2:0]      op_sel_i,
   input  logic [IDXW-1:0] bit_idx_i,
   input  logic            acc_form_i,
   output logic [W-1:0]    result_o,
   output logic            wr_en_o,
   output logic [3:0]      flags_o
);
   flags_t       flg_in;
   flags_t       flg_out;
   logic [W-1:0] sh_res;
   logic         sh_cout;
   logic [W-1:0] fld_res;
   logic         fld_bit;

   assign flg_in = flags_t'(flags_i);

   bitops_shifter #(.W(W)) u_shifter (
      .opnd_i (opnd_i),
      .cin_i  (flg_in.c),
      .op_i   (op_sel_i),
      .res_o  (sh_res),
      .cout_o (sh_cout)
   );

   bitops_field #(.W(W), .IDXW(IDXW)) u_field (
      .opnd_i   (opnd_i),
      .idx_i    (bit_idx_i),
      .force_i  (grp_i[0]),
      .res_o    (fld_res),
      .tested_o (fld_bit)
   );

   bitops_flags #(.W(W)) u_flags (
      .grp_i      (grp_i),
      .op_i       (op_sel_i),
      .acc_form_i (acc_form_i),
      .sh_res_i   (sh_res),
      .sh_cout_i  (sh_cout),
      .tested_i   (fld_bit),
      .flags_i    (flg_in),
      .flags_o    (flg_out),
      .wr_en_o    (wr_en_o)
   );

   always_comb begin
      unique case (grp_e'(grp_i))
         GRP_SHIFT: result_o = sh_res;
         GRP_TEST:  result_o = opnd_i;
         default:   result_o = fld_res;
      endcase
   end

   assign flags_o = flg_out;

   // R6: a bit test passes the operand through untouched
   always_comb begin
      if (grp_e'(grp_i) == GRP_TEST) begin
         p_test_passthru_r6: assert (result_o == opnd_i)
            else $error("p_test_passthru_r6");
      end
   end

   // R7: set/clear change at most one bit of the operand
   always_comb begin
      if (grp_i[1]) begin
         p_field_one_bit_r7: assert ($countones(result_o ^ opnd_i) <= 1)
            else $error("p_field_one_bit_r7");
      end
   end

endmodule

// File: tb/bitops_unit_bench.sv
module bitops_unit_bench;

   logic       clk = 1'b0;
   logic [7:0] opnd;
   logic [3:0] fin;
   logic [1:0] grp;
   logic [2:0] op;
   logic [2:0] idx;
   logic       acc;
   logic [7:0] res;
   logic       wen;
   logic [3:0] fout;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   bitops_unit u_bitops_unit (
      .opnd_i     (opnd),
      .flags_i    (fin),
      .grp_i      (grp),
      .op_sel_i   (op),
      .bit_idx_i  (idx),
      .acc_form_i (acc),
      .result_o   (res),
      .wr_en_o    (wen),
      .flags_o    (fout)
   );

   // expected outputs from the requirements; flags packed {Z,N,H,C}
   function automatic logic [12:0] model(input logic [7:0] d, input logic [3:0] f,
                                          input logic [1:0] g, input logic [2:0] o,
                                          input logic [2:0] n, input logic a);
      logic [7:0] r;
      logic c, z, w;
      logic [3:0] fl;
      c  = f[0];
      w  = 1'b1;
      r  = d;
      fl = f;
      if (g == 2'd0) begin
         case (o)
            3'd0: begin r = {d[6:0], d[7]}; c = d[7]; end
            3'd1: begin r = {d[0], d[7:1]}; c = d[0]; end
            3'd2: begin r = {d[6:0], f[0]}; c = d[7]; end
            3'd3: begin r = {f[0], d[7:1]}; c = d[0]; end
            3'd4: begin r = d << 1;         c = d[7]; end
            3'd5: begin r = {d[7], d[7:1]}; c = d[0]; end
            3'd6: begin r = {d[3:0], d[7:4]}; c = 1'b0; end
            default: begin r = d >> 1;      c = d[0]; end
         endcase
         z = (r == 8'h00);
         if (a && o < 3'd4) z = 1'b0;
         fl = {z, 1'b0, 1'b0, c};
      end else if (g == 2'd1) begin
         w  = 1'b0;
         fl = {~d[n], 1'b0, 1'b1, f[0]};
      end else if (g == 2'd2) begin
         r = d & ~(8'h01 << n);
      end else begin
         r = d | (8'h01 << n);
      end
      return {r, w, fl};
   endfunction

   task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: res=%h wen=%b flags=%b expected res=%h wen=%b flags=%b",
                  req, act[12:5], act[4], act[3:0], exp[12:5], exp[4], exp[3:0]);
      end
   endtask

   // drive on the falling edge, sample a few ns later (no register in the path)
   task automatic apply(input string req, input logic [7:0] d, input logic [3:0] f,
                        input logic [1:0] g, input logic [2:0] o, input logic [2:0] n,
                        input logic a);
      @(negedge clk);
      opnd = d; fin = f; grp = g; op = o; idx = n; acc = a;
      #3;
      check(req, {res, wen, fout}, model(d, f, g, o, n, a));
   endtask

   task automatic t_initial;
      apply("R4 zero operand", 8'h00, 4'h0, 2'd0, 3'd0, 3'd0, 1'b0);
   endtask

   task automatic t_circular;
      logic [7:0] vals [4] = '{8'h80, 8'h01, 8'hA5, 8'h3C};
      foreach (vals[i]) begin
         apply("R1 rotl circ", vals[i], 4'h1, 2'd0, 3'd0, 3'd2, 1'b0);
         apply("R1 rotr circ", vals[i], 4'h0, 2'd0, 3'd1, 3'd5, 1'b0);
      end
   endtask

   task automatic t_through;
      logic [7:0] vals [3] = '{8'h80, 8'h01, 8'h5A};
      foreach (vals[i]) begin
         for (int c = 0; c < 2; c++) begin
            apply("R2 rotl carry", vals[i], {3'b000, c[0]}, 2'd0, 3'd2, 3'd0, 1'b0);
            apply("R2 rotr carry", vals[i], {3'b110, c[0]}, 2'd0, 3'd3, 3'd0, 1'b0);
         end
      end
   endtask

   task automatic t_shifts;
      logic [7:0] vals [4] = '{8'h80, 8'h81, 8'h01, 8'h7E};
      foreach (vals[i]) begin
         apply("R3 shl arith", vals[i], 4'hF, 2'd0, 3'd4, 3'd0, 1'b0);
         apply("R3 shr arith", vals[i], 4'hF, 2'd0, 3'd5, 3'd0, 1'b0);
         apply("R3 shr logic", vals[i], 4'hF, 2'd0, 3'd7, 3'd0, 1'b0);
      end
      apply("R4 shl to zero", 8'h80, 4'h6, 2'd0, 3'd4, 3'd0, 1'b0);
      apply("R4 shr to zero", 8'h01, 4'h6, 2'd0, 3'd7, 3'd0, 1'b0);
   endtask

   task automatic t_swap;
      apply("R5 swap", 8'h12, 4'h7, 2'd0, 3'd6, 3'd0, 1'b0);
      apply("R5 swap", 8'hF0, 4'h1, 2'd0, 3'd6, 3'd0, 1'b0);
      apply("R5 swap zero", 8'h00, 4'h1, 2'd0, 3'd6, 3'd0, 1'b0);
   endtask

   task automatic t_bittest;
      for (int n = 0; n < 8; n++) begin
         apply("R6 bit test", 8'hA5, 4'h5, 2'd1, 3'd0, n[2:0], 1'b0);
         apply("R6 bit test", 8'h5A, 4'h8, 2'd1, 3'd0, n[2:0], 1'b0);
      end
   endtask

   task automatic t_setres;
      for (int n = 0; n < 8; n++) begin
         apply("R7 bit clear", 8'hFF, 4'hA, 2'd2, 3'd0, n[2:0], 1'b0);
         apply("R7 bit set",   8'h00, 4'h5, 2'd3, 3'd0, n[2:0], 1'b0);
      end
      apply("R7 set already set",   8'h10, 4'hF, 2'd3, 3'd0, 3'd4, 1'b0);
      apply("R7 clear already clr", 8'hEF, 4'h0, 2'd2, 3'd0, 3'd4, 1'b0);
   endtask

   task automatic t_accum;
      for (int o = 0; o < 4; o++) begin
         apply("R8 acc rotate", 8'h00, 4'h0, 2'd0, o[2:0], 3'd0, 1'b1);
         apply("R8 acc rotate", 8'h81, 4'h1, 2'd0, o[2:0], 3'd0, 1'b1);
      end
      apply("R8 acc ignored shl",  8'h80, 4'h0, 2'd0, 3'd4, 3'd0, 1'b1);
      apply("R8 acc ignored swap", 8'h00, 4'h0, 2'd0, 3'd6, 3'd0, 1'b1);
      apply("R8 acc ignored test", 8'h00, 4'h1, 2'd1, 3'd0, 3'd3, 1'b1);
      apply("R8 acc ignored set",  8'h00, 4'h9, 2'd3, 3'd0, 3'd1, 1'b1);
   endtask

   task automatic t_ignore;
      for (int n = 0; n < 8; n += 3) begin
         apply("R9 idx ignored shift", 8'hC3, 4'h1, 2'd0, 3'd3, n[2:0], 1'b0);
      end
      for (int o = 0; o < 8; o += 3) begin
         apply("R9 op ignored test",  8'h08, 4'h0, 2'd1, o[2:0], 3'd3, 1'b0);
         apply("R9 op ignored clear", 8'hFF, 4'h3, 2'd2, o[2:0], 3'd6, 1'b0);
         apply("R9 op ignored set",   8'h00, 4'hC, 2'd3, o[2:0], 3'd7, 1'b0);
      end
   endtask

   initial begin
      opnd = 8'h00; fin = 4'h0; grp = 2'd0; op = 3'd0; idx = 3'd0; acc = 1'b0;
      repeat (2) @(posedge clk);
      t_initial();
      t_circular();
      t_through();
      t_shifts();
      t_swap();
      t_bittest();
      t_setres();
      t_accum();
      t_ignore();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule